// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block is the bus-facing side of a multi-channel interval timer. A host reaches it through one small byte-wide port with a two-bit offset. Offsets 0, 1 and 2 are the count ports of channels 0, 1 and 2, and offset 3 is the control port. A byte written to the control port is a control word. The control word either reprograms one channel or asks that channel to freeze its running count for reading. A byte written to a count port becomes part of that channel's new initial count. The block issues a one-cycle load strobe together with the assembled 16-bit value once the channel's chosen byte sequence is complete.

The counters themselves are outside this block. It receives each channel's live count and drives, for each channel, the counting mode, the BCD flag, a reprogram pulse and the initial-count load strobe. Reads of a count port return either the live count or a frozen snapshot. Bytes are returned in the order the channel's access mode sets. Taking a snapshot never disturbs the counter.

Top module: `tmr_host_if`

## Requirements
- R1: After reset every channel has counting mode 0, BCD flag 0 and access mode low-then-high, with both byte toggles at the low byte and no snapshot held. All load and reprogram pulses are low.
- R2: A control word is split into fields as follows: bits 7:6 select the channel, bits 5:4 give the access mode (00 snapshot, 01 low byte only, 10 high byte only, 11 low then high), bits 3:1 give the counting mode and bit 0 the BCD flag. A control word with a nonzero access field updates the selected channel's mode and BCD outputs on the next edge and pulses that channel's reprogram bit for one cycle. Mode and BCD outputs change only on such a write.
- R3: A control word with bits 7:6 equal to 11 changes nothing.
- R4: In low-only mode each count write loads {8'h00, byte} with a one-cycle load strobe on the next cycle. Only one channel strobes in any cycle.
- R5: In high-only mode each count write loads {byte, 8'h00} with a one-cycle load strobe.
- R6: In low-then-high mode the first write holds the low byte without loading. The second write loads {second, first}.
- R7: A reprogramming control word returns the channel's write toggle to the low byte, discarding a held low byte.
- R8: Without a snapshot a count read returns the live count: the low byte in low-only mode, the high byte in high-only mode, and alternately low then high in low-then-high mode.
- R9: A snapshot command captures the channel's count at that clock edge. Later reads return the captured bytes while the live count moves. A snapshot command leaves mode, BCD and access mode unchanged.
- R10: A snapshot is released once it has been fully read, meaning both bytes in low-then-high mode or the one byte otherwise. After that, reads return the live count again.
- R11: A snapshot command for a channel that already holds an unread snapshot is ignored.
- R12: A reprogramming control word drops a held snapshot and returns the read toggle to the low byte.
- R13: A read at the control offset returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Offset: 0..2 count ports, 3 control port |
| wr_i | input | 1 | Write strobe for wdata_i at addr_i |
| rd_i | input | 1 | Read strobe; advances read sequencing at the edge |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte for addr_i (combinational) |
| count_i | input | 48 | Live 16-bit count per channel, channel c at bits 16c+15:16c |
| mode_o | output | 9 | Counting mode per channel, channel c at bits 3c+2:3c |
| bcd_o | output | 3 | BCD flag per channel |
| ctrl_o | output | 3 | One-cycle pulse per channel on a reprogramming control word |
| load_o | output | 3 | One-cycle initial-count load strobe per channel |
| init_o | output | 48 | Assembled initial count per channel, channel c at bits 16c+15:16c |

## Verification
Two things can happen on the same clock edge: a snapshot capture and a change in the live count that is being captured. The bench provokes this by moving every channel's count on each cycle while it issues snapshot commands. The captured value must be the count present at that capturing edge, and not the one before or after it. A reference model then compares every later read byte against that snapshot, while the live input keeps changing, until the snapshot is released. At the release point it also checks that the reads switch back to live data.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int MW = 3;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_WORD = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e          acc;
    logic [MW-1:0] mode;
    logic          bcd;
  } cfg_t;
endpackage

// File: rtl/tmr_ctrl_dec.sv
module tmr_ctrl_dec
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic           wr_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [7:0]     wdata_i,
  output cfg_t           cfg_o,
  output logic [NCH-1:0] cfg_we_o,
  output logic [NCH-1:0] snap_o,
  output logic [NCH-1:0] cnt_wr_o
);
  localparam logic [AW-1:0] CTRL = AW'(NCH);

  logic ctl_wr;
  assign ctl_wr = wr_i && (addr_i == CTRL);
  assign cfg_o  = cfg_t'(wdata_i[5:0]);

  always_comb begin
    cfg_we_o = '0;
    snap_o   = '0;
    cnt_wr_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ctl_wr && int'(wdata_i[7:6]) == c) begin
        if (acc_e'(wdata_i[5:4]) == ACC_SNAP) snap_o[c] = 1'b1;
        else                                  cfg_we_o[c] = 1'b1;
      end
      cnt_wr_o[c] = wr_i && (addr_i == AW'(c));
    end
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_pkg::*;
#(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  cfg_t          cfg_i,
  input  logic          snap_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [BW-1:0] wdata_i,
  input  logic [CW-1:0] count_i,
  output logic [BW-1:0] rdata_o,
  output logic [MW-1:0] mode_o,
  output logic          bcd_o,
  output logic          ctrl_o,
  output logic          load_o,
  output logic [CW-1:0] init_o
);
  acc_e          acc_q;
  logic          wtog_q, rtog_q, held_q;
  logic [CW-1:0] snap_q;
  logic [BW-1:0] lo_q;
  logic [CW-1:0] src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= ACC_WORD;
      mode_o <= '0;
      bcd_o  <= 1'b0;
      wtog_q <= 1'b0;
      rtog_q <= 1'b0;
      held_q <= 1'b0;
      snap_q <= '0;
      lo_q   <= '0;
      init_o <= '0;
      load_o <= 1'b0;
      ctrl_o <= 1'b0;
    end else begin
      load_o <= 1'b0;
      ctrl_o <= 1'b0;
      if (cfg_we_i) begin
        acc_q  <= cfg_i.acc;
        mode_o <= cfg_i.mode;
        bcd_o  <= cfg_i.bcd;
        wtog_q <= 1'b0;
        rtog_q <= 1'b0;
        held_q <= 1'b0;
        ctrl_o <= 1'b1;
      end else begin
        if (snap_i && !held_q) begin
          held_q <= 1'b1;
          snap_q <= count_i;
        end
        if (wr_i) begin
          unique case (acc_q)
            ACC_LO: begin
              init_o <= {{BW{1'b0}}, wdata_i};
              load_o <= 1'b1;
            end
            ACC_HI: begin
              init_o <= {wdata_i, {BW{1'b0}}};
              load_o <= 1'b1;
            end
            default: begin
              if (!wtog_q) begin
                lo_q   <= wdata_i;
                wtog_q <= 1'b1;
              end else begin
                init_o <= {wdata_i, lo_q};
                load_o <= 1'b1;
                wtog_q <= 1'b0;
              end
            end
          endcase
        end
        if (rd_i) begin
          if (acc_q == ACC_WORD) rtog_q <= ~rtog_q;
          // release after last byte of the snapshot
          if (held_q && (acc_q != ACC_WORD || rtog_q)) held_q <= 1'b0;
        end
      end
    end
  end

  assign src = held_q ? snap_q : count_i;

  always_comb begin
    unique case (acc_q)
      ACC_LO:  rdata_o = src[BW-1:0];
      ACC_HI:  rdata_o = src[CW-1:BW];
      default: rdata_o = rtog_q ? src[CW-1:BW] : src[BW-1:0];
    endcase
  end
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int BW  = 8,
  localparam int CW = 2 * BW,
  localparam int AW = $clog2(NCH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BW-1:0]     wdata_i,
  output logic [BW-1:0]     rdata_o,
  input  logic [NCH*CW-1:0] count_i,
  output logic [NCH*MW-1:0] mode_o,
  output logic [NCH-1:0]    bcd_o,
  output logic [NCH-1:0]    ctrl_o,
  output logic [NCH-1:0]    load_o,
  output logic [NCH*CW-1:0] init_o
);
  cfg_t           cfg;
  logic [NCH-1:0] cfg_we, snap, cnt_wr;
  logic [BW-1:0]  ch_rd [NCH];

  tmr_ctrl_dec #(.NCH(NCH), .AW(AW)) u_dec (
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cfg_o   (cfg),
    .cfg_we_o(cfg_we),
    .snap_o  (snap),
    .cnt_wr_o(cnt_wr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic rd_c;
    assign rd_c = rd_i && (addr_i == AW'(c));
    tmr_chan_port #(.BW(BW)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cfg_we_i(cfg_we[c]),
      .cfg_i   (cfg),
      .snap_i  (snap[c]),
      .wr_i    (cnt_wr[c]),
      .rd_i    (rd_c),
      .wdata_i (wdata_i),
      .count_i (count_i[c*CW +: CW]),
      .rdata_o (ch_rd[c]),
      .mode_o  (mode_o[c*MW +: MW]),
      .bcd_o   (bcd_o[c]),
      .ctrl_o  (ctrl_o[c]),
      .load_o  (load_o[c]),
      .init_o  (init_o[c*CW +: CW])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++)
      if (addr_i == AW'(c)) rdata_o = ch_rd[c];
  end
endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk #(
  parameter int NCH = 3,
  parameter int BW  = 8,
  parameter int MW  = 3,
  parameter int AW  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [3:0]        ctl_hi_i,
  input logic [BW-1:0]     rdata_o,
  input logic [NCH*MW-1:0] mode_o,
  input logic [NCH-1:0]    bcd_o,
  input logic [NCH-1:0]    ctrl_o,
  input logic [NCH-1:0]    load_o
);
  localparam logic [AW-1:0] CTRL = AW'(NCH);

  p_load_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));

  p_reserved_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == CTRL && ctl_hi_i[3:2] == 2'b11)
    |=> (ctrl_o == '0) && (load_o == '0) && $stable(mode_o) && $stable(bcd_o));

  p_cfg_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == CTRL && ctl_hi_i[3:2] != 2'b11 && ctl_hi_i[1:0] != 2'b00)
    |=> ctrl_o == (NCH'(1) << $past(ctl_hi_i[3:2])));

  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == CTRL) |=> $stable(mode_o) && $stable(bcd_o) && ctrl_o == '0);

  p_snap_no_cfg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == CTRL && ctl_hi_i[1:0] == 2'b00)
    |=> $stable(mode_o) && $stable(bcd_o) && ctrl_o == '0);

  p_load_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o != '0) |-> $past(wr_i && addr_i != CTRL));

  p_ctl_read_zero_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == CTRL) |-> rdata_o == '0);
endmodule

bind tmr_host_if tmr_host_if_chk #(.NCH(NCH), .BW(BW), .MW(tmr_pkg::MW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .ctl_hi_i(wdata_i[7:4]),
  .rdata_o (rdata_o),
  .mode_o  (mode_o),
  .bcd_o   (bcd_o),
  .ctrl_o  (ctrl_o),
  .load_o  (load_o)
);

// File: tb/tmr_host_if_bench.sv
module tmr_host_if_bench;
  localparam int NCH = 3;
  localparam int CW  = 16;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [NCH*CW-1:0] count = '0;
  logic [7:0] rdata;
  logic [NCH*3-1:0] mode_o;
  logic [NCH-1:0] bcd_o, ctrl_o, load_o;
  logic [NCH*CW-1:0] init_o;

  tmr_host_if u_tmr_host_if (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .count_i(count), .mode_o(mode_o),
    .bcd_o(bcd_o), .ctrl_o(ctrl_o), .load_o(load_o), .init_o(init_o)
  );

  // reference model state
  int acc_m[NCH], mode_m[NCH], bcd_m[NCH], wt_m[NCH], rt_m[NCH];
  int held_m[NCH], snap_m[NCH], lo_m[NCH], init_m[NCH], load_m[NCH], ctrl_m[NCH];
  int checks = 0, errors = 0;
  string tag = "R1";
  bit run = 0;
  bit done = 0;

  function automatic int cnt(int c);
    return int'(count[c*CW +: CW]);
  endfunction

  function automatic int exp_rd();
    int c, src;
    if (addr == 2'd3) return 0;
    c = int'(addr);
    src = held_m[c] ? snap_m[c] : cnt(c);
    case (acc_m[c])
      1: return src & 255;
      2: return (src >> 8) & 255;
      default: return rt_m[c] ? ((src >> 8) & 255) : (src & 255);
    endcase
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      acc_m[c] = 3; mode_m[c] = 0; bcd_m[c] = 0; wt_m[c] = 0; rt_m[c] = 0;
      held_m[c] = 0; snap_m[c] = 0; lo_m[c] = 0; init_m[c] = 0;
      load_m[c] = 0; ctrl_m[c] = 0;
    end
  endtask

  always @(posedge clk) if (rst_n) begin
    for (int c = 0; c < NCH; c++) begin load_m[c] = 0; ctrl_m[c] = 0; end
    if (wr && addr == 2'd3) begin
      int s, a;
      s = int'(wdata[7:6]); a = int'(wdata[5:4]);
      if (s != 3) begin
        if (a == 0) begin
          if (!held_m[s]) begin held_m[s] = 1; snap_m[s] = cnt(s); end
        end else begin
          acc_m[s] = a; mode_m[s] = int'(wdata[3:1]); bcd_m[s] = int'(wdata[0]);
          wt_m[s] = 0; rt_m[s] = 0; held_m[s] = 0; ctrl_m[s] = 1;
        end
      end
    end else if (wr) begin
      int c;
      c = int'(addr);
      if (acc_m[c] == 1) begin init_m[c] = int'(wdata); load_m[c] = 1; end
      else if (acc_m[c] == 2) begin init_m[c] = int'(wdata) * 256; load_m[c] = 1; end
      else if (!wt_m[c]) begin lo_m[c] = int'(wdata); wt_m[c] = 1; end
      else begin init_m[c] = int'(wdata) * 256 + lo_m[c]; load_m[c] = 1; wt_m[c] = 0; end
    end
    if (rd && addr != 2'd3) begin
      int c;
      c = int'(addr);
      if (held_m[c] && (acc_m[c] != 3 || rt_m[c])) held_m[c] = 0;
      if (acc_m[c] == 3) rt_m[c] = 1 - rt_m[c];
    end
  end

  task automatic cmp_regs();
    for (int c = 0; c < NCH; c++) begin
      chk(int'(mode_o[c*3 +: 3]) == mode_m[c], "mode", int'(mode_o[c*3 +: 3]), mode_m[c]);
      chk(int'(bcd_o[c]) == bcd_m[c], "bcd", int'(bcd_o[c]), bcd_m[c]);
      chk(int'(ctrl_o[c]) == ctrl_m[c], "ctrl", int'(ctrl_o[c]), ctrl_m[c]);
      chk(int'(load_o[c]) == load_m[c], "load", int'(load_o[c]), load_m[c]);
      chk(int'(init_o[c*CW +: CW]) == init_m[c], "init", int'(init_o[c*CW +: CW]), init_m[c]);
    end
  endtask

  task automatic step(bit w, bit r, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cmp_regs();
    wr = w; rd = r; addr = a; wdata = d;
    if (run)
      for (int c = 0; c < NCH; c++) count[c*CW +: CW] += 16'(7 * (c + 1) + 250);
    #1;
    chk(int'(rdata) == exp_rd(), "rdata", int'(rdata), exp_rd());
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'd0, 8'h00);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL %s watchdog: actual %0d expected %0d", tag, 0, 1);
      report();
    end
  end

  initial begin
    model_reset();
    count = {16'h3003, 16'h2002, 16'h1001};
    #7;
    tag = "R1";
    cmp_regs();
    rst_n = 1;
    idle(2);

    tag = "R2";
    step(1, 0, 2'd3, 8'h75);          // ch1 word, mode 2, bcd
    step(1, 0, 2'd3, 8'h96);          // ch2 low-only, mode 3
    idle(1);
    tag = "R3";
    step(1, 0, 2'd3, 8'hFF);
    step(1, 0, 2'd3, 8'hC4);
    idle(1);

    tag = "R4";
    step(1, 0, 2'd2, 8'h5A);
    idle(1);
    tag = "R5";
    step(1, 0, 2'd3, 8'h20);          // ch0 high-only
    step(1, 0, 2'd0, 8'h3C);
    idle(1);
    tag = "R6";
    step(1, 0, 2'd1, 8'h34);
    idle(1);
    step(1, 0, 2'd1, 8'h12);
    idle(1);
    tag = "R7";
    step(1, 0, 2'd1, 8'h99);
    step(1, 0, 2'd3, 8'h74);
    step(1, 0, 2'd1, 8'h78);
    step(1, 0, 2'd1, 8'h56);
    idle(1);

    tag = "R8";
    run = 1;
    step(0, 1, 2'd1, 8'h00);
    step(0, 1, 2'd1, 8'h00);
    step(0, 1, 2'd2, 8'h00);
    step(0, 1, 2'd0, 8'h00);
    idle(1);

    tag = "R9";
    step(1, 0, 2'd3, 8'h40);          // snapshot ch1 while count moves
    idle(3);
    step(0, 1, 2'd1, 8'h00);
    idle(2);
    step(0, 1, 2'd1, 8'h00);
    tag = "R10";
    step(0, 1, 2'd1, 8'h00);
    step(0, 1, 2'd1, 8'h00);
    idle(1);

    tag = "R11";
    step(1, 0, 2'd3, 8'h80);
    idle(2);
    step(1, 0, 2'd3, 8'h80);
    idle(2);
    step(0, 1, 2'd2, 8'h00);
    step(0, 1, 2'd2, 8'h00);
    idle(1);

    tag = "R12";
    step(1, 0, 2'd3, 8'h40);
    step(0, 1, 2'd1, 8'h00);
    step(1, 0, 2'd3, 8'h76);
    step(0, 1, 2'd1, 8'h00);
    step(0, 1, 2'd1, 8'h00);
    idle(1);

    tag = "R13";
    step(0, 1, 2'd3, 8'h00);
    idle(2);

    done = 1;
    report();
  end
endmodule